// File: doc/BRIEF.md
# Timed-Edge Lane Bridge

This block links ordinary one-bit logic and the timed-edge lane form that timed logic cells use inside each reference-clock cycle. A lane holds the level the signal starts the cycle with and up to two transition slots. Each slot has a valid flag, a sub-cycle offset and the level the signal takes after that transition.

The encoding path watches a plain bit once per reference cycle. A change becomes a single transition at offset zero. No change becomes a steady lane at the level held from the cycle before. The decoding path reduces an incoming lane to the level it settles at by the end of the cycle. A build-time mode picks when that level reaches the plain output: at once (offset zero), at the falling edge of the reference clock in the same cycle, or at the next rising edge.

Lane layout, with `OFS_W` offset bits: bit 0 is the start level. Slot k fills bits `[1+k*(OFS_W+2) +: OFS_W+2]`. Inside a slot, bit 0 is the new level, bits `OFS_W:1` are the offset and the top bit is the valid flag.

Top module: `edge_lane_bridge`

## Requirements
- R1: The settled level of an incoming lane is the new level of the valid slot with the largest offset. When no slot is valid, it is the start level.
- R2: When the plain input differs from the level held from the previous cycle, the next encoded lane has its start level equal to that held level. Slot 0 is valid with offset 0 and new level equal to the input, and slot 1 is all zero.
- R3: When the plain input equals the held level, the next encoded lane has start level equal to the input and every slot field is zero.
- R4: Reset is synchronous and active-high. It clears the held level to low. The encoded lane reads all zero through reset and for the first cycle after it. A high input at that point then appears as a transition from low.
- R5: In rising mode, the plain output takes the settled level of the lane present before a rising edge, and holds it until the next rising edge.
- R6: In falling mode, the plain output takes the settled level at the falling edge inside the same reference cycle.
- R7: In zero-offset mode, the plain output follows the settled level of the current lane with no register.
- R8: An incoming lane may use slot 1 only when slot 0 is also valid with a strictly smaller offset. This keeps a lane to two ordered edges per cycle.
- R9: A plain bit passed through the encoder and then the decoder comes back unchanged in every presentation mode.
- R10: In falling and rising modes, reset drives the plain output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| plain_in | input | 1 | Ordinary bit to encode |
| lane_out | output | 1+2*(OFS_W+2) | Encoded lane for plain_in |
| lane_in | input | 1+2*(OFS_W+2) | Encoded lane to decode |
| plain_out | output | 1 | Settled level, presented per MODE |

## Verification
On every clock the assertions check four things: that incoming lanes keep their two slots in ascending order, that each encoded start level repeats the level at which the previous lane ended, that the encoded lane is empty in the first cycle after reset, and that rising-mode output lags the settled level by exactly one edge. The bench's scenarios are needed for the rest. They compare the three presentation modes at sample points before and after the falling edge. They compute settled levels for lanes with zero, one or two edges. They test the low start after a reset in mid-run, and they run random bits through the encoder and back into the decoder.

// File: rtl/elb_pkg.sv
package elb_pkg;

    // When the settled level of a lane reaches the plain output
    typedef enum logic [1:0] {
        PRES_ZERO = 2'd0,
        PRES_FALL = 2'd1,
        PRES_RISE = 2'd2
    } pres_mode_e;

    // Transition slots carried per reference cycle
    localparam int SLOTS = 2;

    function automatic int slot_width(int ofs_w);
        return ofs_w + 2;
    endfunction

    function automatic int lane_width(int ofs_w);
        return 1 + SLOTS * slot_width(ofs_w);
    endfunction

endpackage

// File: rtl/elb_encoder.sv
module elb_encoder
    import elb_pkg::*;
#(
    parameter int OFS_W = 4,
    localparam int LW = lane_width(OFS_W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          plain_in,
    output logic [LW-1:0] lane_out
);

    typedef struct packed {
        logic             vld;
        logic [OFS_W-1:0] ofs;
        logic             lvl;
    } edge_t;

    typedef struct packed {
        edge_t [SLOTS-1:0] tr;
        logic              start;
    } lane_t;

    logic  held_q;
    lane_t lane_q;
    lane_t lane_nxt;

    always_comb begin
        lane_nxt       = '0;
        lane_nxt.start = held_q;
        if (plain_in != held_q) begin
            lane_nxt.tr[0].vld = 1'b1;
            lane_nxt.tr[0].lvl = plain_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= 1'b0;
            lane_q <= '0;
        end else begin
            held_q <= plain_in;
            lane_q <= lane_nxt;
        end
    end

    assign lane_out = lane_q;

    // R2 R3
    property start_follows_prior_p;
        @(posedge clk) disable iff (rst)
        1'b1 |=> lane_q.start == ($past(lane_q.tr[0].vld) ? $past(lane_q.tr[0].lvl)
                                                          : $past(lane_q.start));
    endproperty
    start_continuity_chk: assert property (start_follows_prior_p);

    // R4
    property empty_after_reset_p;
        @(posedge clk) disable iff (rst)
        $fell(rst) |-> lane_q == '0;
    endproperty
    first_cycle_quiet_chk: assert property (empty_after_reset_p);

endmodule

// File: rtl/elb_resolver.sv
module elb_resolver
    import elb_pkg::*;
#(
    parameter int OFS_W = 4,
    localparam int LW = lane_width(OFS_W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [LW-1:0] lane_in,
    output logic          settled
);

    typedef struct packed {
        logic             vld;
        logic [OFS_W-1:0] ofs;
        logic             lvl;
    } edge_t;

    typedef struct packed {
        edge_t [SLOTS-1:0] tr;
        logic              start;
    } lane_t;

    lane_t lane;
    assign lane = lane_t'(lane_in);

    // The latest valid edge wins; on equal offsets the higher slot wins
    always_comb begin
        logic             found;
        logic [OFS_W-1:0] best;
        found   = 1'b0;
        best    = '0;
        settled = lane.start;
        for (int k = 0; k < SLOTS; k++) begin
            if (lane.tr[k].vld && (!found || lane.tr[k].ofs >= best)) begin
                found   = 1'b1;
                best    = lane.tr[k].ofs;
                settled = lane.tr[k].lvl;
            end
        end
    end

    generate
        for (genvar k = 1; k < SLOTS; k++) begin : g_order
            // R8
            property ordered_slot_p;
                @(posedge clk) disable iff (rst)
                lane.tr[k].vld |-> (lane.tr[k-1].vld && (lane.tr[k-1].ofs < lane.tr[k].ofs));
            endproperty
            lane_order_chk: assert property (ordered_slot_p);
        end
    endgenerate

endmodule

// File: rtl/elb_presenter.sv
module elb_presenter
    import elb_pkg::*;
#(
    parameter pres_mode_e MODE = PRES_RISE
) (
    input  logic clk,
    input  logic rst,
    input  logic level_in,
    output logic plain_out
);

    generate
        if (MODE == PRES_ZERO) begin : g_zero
            assign plain_out = level_in;
        end else if (MODE == PRES_FALL) begin : g_fall
            logic fall_q;
            always_ff @(negedge clk) begin
                if (rst) fall_q <= 1'b0;
                else     fall_q <= level_in;
            end
            assign plain_out = fall_q;
        end else begin : g_rise
            logic rise_q;
            logic seen_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    rise_q <= 1'b0;
                    seen_q <= 1'b0;
                end else begin
                    rise_q <= level_in;
                    seen_q <= 1'b1;
                end
            end
            assign plain_out = rise_q;

            // R5
            property rise_one_edge_p;
                @(posedge clk) disable iff (rst)
                seen_q |-> plain_out == $past(level_in);
            endproperty
            rise_lag_chk: assert property (rise_one_edge_p);
        end
    endgenerate

endmodule

// File: rtl/edge_lane_bridge.sv
module edge_lane_bridge
    import elb_pkg::*;
#(
    parameter int         OFS_W = 4,
    parameter pres_mode_e MODE  = PRES_RISE,
    localparam int LW = lane_width(OFS_W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          plain_in,
    output logic [LW-1:0] lane_out,
    input  logic [LW-1:0] lane_in,
    output logic          plain_out
);

    logic settled;

    elb_encoder #(.OFS_W(OFS_W)) u_encoder (
        .clk      (clk),
        .rst      (rst),
        .plain_in (plain_in),
        .lane_out (lane_out)
    );

    elb_resolver #(.OFS_W(OFS_W)) u_resolver (
        .clk     (clk),
        .rst     (rst),
        .lane_in (lane_in),
        .settled (settled)
    );

    elb_presenter #(.MODE(MODE)) u_presenter (
        .clk       (clk),
        .rst       (rst),
        .level_in  (settled),
        .plain_out (plain_out)
    );

endmodule

// File: tb/edge_lane_bridge_bench.sv
module edge_lane_bridge_bench;
    import elb_pkg::*;

    localparam int OFS_W = 4;
    localparam int LW    = lane_width(OFS_W);

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic          rst     = 1'b1;
    logic          pin     = 1'b0;
    logic          loop_en = 1'b0;
    logic [LW-1:0] lane_drv = '0;

    logic [LW-1:0] enc_r, enc_f, enc_z;
    logic          out_r, out_f, out_z;
    logic [LW-1:0] lane_feed;
    assign lane_feed = loop_en ? enc_r : lane_drv;

    edge_lane_bridge #(.OFS_W(OFS_W), .MODE(PRES_RISE)) u_edge_lane_bridge (
        .clk(clk), .rst(rst), .plain_in(pin), .lane_out(enc_r),
        .lane_in(lane_feed), .plain_out(out_r));

    edge_lane_bridge #(.OFS_W(OFS_W), .MODE(PRES_FALL)) u_edge_lane_bridge_fall (
        .clk(clk), .rst(rst), .plain_in(pin), .lane_out(enc_f),
        .lane_in(lane_feed), .plain_out(out_f));

    edge_lane_bridge #(.OFS_W(OFS_W), .MODE(PRES_ZERO)) u_edge_lane_bridge_zero (
        .clk(clk), .rst(rst), .plain_in(pin), .lane_out(enc_z),
        .lane_in(lane_feed), .plain_out(out_z));

    int checks = 0;
    int errors = 0;

    task automatic chk(string req, logic [LW-1:0] act, logic [LW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic             pin;
        logic             st;
        logic             v0;
        logic [OFS_W-1:0] o0;
        logic             l0;
        logic             v1;
        logic [OFS_W-1:0] o1;
        logic             l1;
        logic             exp;
    } vec_t;

    // plain bit, start, slot0 {v,ofs,lvl}, slot1 {v,ofs,lvl}, settled level
    localparam vec_t VECS [0:9] = '{
        {1'b1, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 4'd0,  1'b0, 1'b0},
        {1'b1, 1'b1, 1'b1, 4'd3,  1'b0, 1'b0, 4'd0,  1'b0, 1'b0},
        {1'b0, 1'b0, 1'b1, 4'd2,  1'b1, 1'b1, 4'd9,  1'b0, 1'b0},
        {1'b0, 1'b1, 1'b0, 4'd0,  1'b0, 1'b0, 4'd0,  1'b0, 1'b1},
        {1'b1, 1'b0, 1'b1, 4'd0,  1'b1, 1'b1, 4'd15, 1'b1, 1'b1},
        {1'b1, 1'b0, 1'b1, 4'd5,  1'b1, 1'b0, 4'd0,  1'b0, 1'b1},
        {1'b0, 1'b1, 1'b1, 4'd1,  1'b0, 1'b1, 4'd2,  1'b1, 1'b1},
        {1'b1, 1'b1, 1'b1, 4'd14, 1'b0, 1'b1, 4'd15, 1'b0, 1'b0},
        {1'b0, 1'b0, 1'b1, 4'd0,  1'b0, 1'b0, 4'd0,  1'b0, 1'b0},
        {1'b0, 1'b1, 1'b1, 4'd7,  1'b1, 1'b0, 4'd0,  1'b0, 1'b1}
    };

    function automatic logic [LW-1:0] mk_lane(vec_t v);
        logic [LW-1:0] l;
        l = {v.v1, v.o1, v.l1, v.v0, v.o0, v.l0, v.st};
        return l;
    endfunction

    // Expected encoder lane per R2/R3: bit0 start, bit1 slot0 level, bit6 slot0 valid
    function automatic logic [LW-1:0] enc_exp(logic p, logic prev);
        logic [LW-1:0] e;
        e    = '0;
        e[0] = prev;
        if (p != prev) begin
            e[1]         = p;
            e[OFS_W + 2] = 1'b1;
        end
        return e;
    endfunction

    initial begin
        #(8 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic prev;
        logic prev_exp;
        repeat (3) @(posedge clk);
        #2;
        // R4 R10: state while reset is held
        chk("R4 reset lane", enc_r, '0);
        chk("R10 rise out", LW'(out_r), '0);
        chk("R10 fall out", LW'(out_f), '0);
        rst = 1'b0;
        #1;
        chk("R4 first cycle lane", enc_r, '0);
        @(posedge clk);
        #2;
        prev     = 1'b0;
        prev_exp = 1'b0;

        for (int i = 0; i < 10; i++) begin
            pin      = VECS[i].pin;
            lane_drv = mk_lane(VECS[i]);
            #1;
            chk(VECS[i].v1 ? "R7 R1 R8 zero mode" : "R7 R1 zero mode", LW'(out_z), LW'(VECS[i].exp));
            chk("R5 rise holds", LW'(out_r), LW'(prev_exp));
            chk("R6 fall before negedge", LW'(out_f), LW'(prev_exp));
            #2;
            chk("R6 fall after negedge", LW'(out_f), LW'(VECS[i].exp));
            chk("R5 rise before edge", LW'(out_r), LW'(prev_exp));
            @(posedge clk);
            #2;
            chk("R5 R1 rise after edge", LW'(out_r), LW'(VECS[i].exp));
            chk((pin != prev) ? "R2 change" : "R3 steady", enc_r, enc_exp(pin, prev));
            prev     = pin;
            prev_exp = VECS[i].exp;
        end

        // R9: encoder looped back into the decoder
        loop_en = 1'b1;
        for (int i = 0; i < 40; i++) begin
            pin = 1'($urandom());
            @(posedge clk);
            @(posedge clk);
            #2;
            chk("R9 rise round trip", LW'(out_r), LW'(pin));
            chk("R9 fall round trip", LW'(out_f), LW'(pin));
            chk("R9 zero round trip", LW'(out_z), LW'(pin));
        end

        // R4 R10: reset in mid-run with the input high
        loop_en  = 1'b0;
        lane_drv = '0;
        pin      = 1'b1;
        rst      = 1'b1;
        @(posedge clk);
        #2;
        chk("R4 mid reset lane", enc_r, '0);
        chk("R10 mid reset rise", LW'(out_r), '0);
        chk("R10 mid reset fall", LW'(out_f), '0);
        rst = 1'b0;
        #1;
        chk("R4 first cycle after mid reset", enc_r, '0);
        @(posedge clk);
        #2;
        chk("R4 held level low after reset", enc_r, enc_exp(1'b1, 1'b0));
        @(posedge clk);
        #2;
        chk("R3 steady after reset", enc_r, enc_exp(1'b1, 1'b1));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule